// File: doc/BRIEF.md
# Miss-Rate Driven Cache Partition Controller

This block sits beside a set-associative cache whose ways are split between instruction and data. The partition value is the number of ways that belong to instructions: ways 0 up to one below that value hold instructions, and the remaining ways hold data. For each cache access the controller receives one pulse, tagged with its type and whether it missed. It counts the accesses and misses of each type over an epoch of a fixed number of accesses. At the end of each epoch it decides whether the boundary should move by one way.

The two miss rates are compared by cross-multiplication, so no divider is needed. The boundary moves toward the type with the worse miss rate only when the gap is strictly larger than a threshold fraction, and it stays within configured lower and upper limits. When it moves, the way that changes owner is invalidated one set per cycle through a command interface. During that walk the controller raises a busy flag and keeps presenting the old partition value.

Top module: `repart_ctrl`

## Requirements
- R1: After reset the partition output equals INIT_IWAYS, and busy and the invalidate valid are low.
- R2: An epoch closes on exactly the PERIOD-th access counted since reset or since the previous close. Accesses of both types count toward PERIOD. All counters restart from zero for the next epoch, and fewer accesses never trigger an evaluation.
- R3: An epoch where missI*accD*THR_DEN exceeds missD*accI*THR_DEN + THR_NUM*accI*accD, with the partition below MAX_IWAYS, raises the partition by one. This test is made before the test in R4.
- R4: An epoch where missD*accI*THR_DEN exceeds missI*accD*THR_DEN + THR_NUM*accI*accD, with the partition above MIN_IWAYS, lowers the partition by one.
- R5: A miss-rate gap equal to or below the threshold (0.02 by default) leaves the partition unchanged and starts no walk.
- R6: The partition never leaves the range MIN_IWAYS to MAX_IWAYS. A request to move past a limit has no effect.
- R7: An epoch in which either type had zero accesses makes no adjustment.
- R8: A move starts an invalidate walk on the second clock edge after the access that closes the epoch. The walk targets way P when growing from P, and way P-1 when shrinking from P. The set index goes 0,1,...,SETS-1, one per cycle. The invalidate valid and busy are high for exactly SETS cycles.
- R9: The partition output keeps its old value during the walk and takes the new value on the edge that ends the last beat.
- R10: The partition changes by at most one step per epoch, and only at the end of a walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_vld_i | input | 1 | One cache access in this cycle |
| acc_is_data_i | input | 1 | 1 = data access, 0 = instruction access |
| acc_miss_i | input | 1 | The access missed |
| part_o | output | $clog2(WAYS+1) | Number of instruction ways (index of first data way) |
| busy_o | output | 1 | Invalidate walk in progress |
| inv_vld_o | output | 1 | Invalidate command valid this cycle |
| inv_way_o | output | $clog2(WAYS) | Way to invalidate |
| inv_set_o | output | $clog2(SETS) | Set to invalidate |

## Verification
The bench aims at the threshold edge. A gap of exactly 0.02 must not move the boundary, and 0.04 must move it. A comparison written with >= or with the wrong operand order would move early or move the wrong way. Repeated moves in one direction drive the partition against each limit, where a missing bound check would step past it. An epoch with only one type would adjust on a zero denominator if R7 were missed. A 99-access epoch followed by one more access checks that the evaluation fires on exactly the PERIOD-th access and not one early. A wrong way choice or an early partition update shows up in the per-clock comparison of the walk.

// File: rtl/repart_pkg.sv
package repart_pkg;
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;
endpackage

// File: rtl/rp_epoch_cnt.sv
module rp_epoch_cnt #(
  parameter int PERIOD = 100000,
  parameter int CNT_W  = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_vld,
  input  logic             acc_is_data,
  input  logic             acc_miss,
  output logic [CNT_W-1:0] snap_iacc,
  output logic [CNT_W-1:0] snap_imiss,
  output logic [CNT_W-1:0] snap_dacc,
  output logic [CNT_W-1:0] snap_dmiss,
  output logic             eval
);
  logic [CNT_W-1:0] tot_q, iacc_q, imiss_q, dacc_q, dmiss_q;
  logic [CNT_W-1:0] tot_d, iacc_d, imiss_d, dacc_d, dmiss_d;
  logic [CNT_W-1:0] iacc_n, imiss_n, dacc_n, dmiss_n;
  logic             close;

  // counts including the access of this cycle
  always_comb begin
    iacc_n  = iacc_q  + CNT_W'(acc_vld & ~acc_is_data);
    imiss_n = imiss_q + CNT_W'(acc_vld & ~acc_is_data & acc_miss);
    dacc_n  = dacc_q  + CNT_W'(acc_vld & acc_is_data);
    dmiss_n = dmiss_q + CNT_W'(acc_vld & acc_is_data & acc_miss);
    close   = acc_vld && (tot_q == CNT_W'(PERIOD - 1));
    if (close) begin
      tot_d = '0; iacc_d = '0; imiss_d = '0; dacc_d = '0; dmiss_d = '0;
    end else begin
      tot_d = tot_q + 1'b1;
      iacc_d = iacc_n; imiss_d = imiss_n; dacc_d = dacc_n; dmiss_d = dmiss_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tot_q <= '0; iacc_q <= '0; imiss_q <= '0; dacc_q <= '0; dmiss_q <= '0;
      snap_iacc <= '0; snap_imiss <= '0; snap_dacc <= '0; snap_dmiss <= '0;
      eval <= 1'b0;
    end else begin
      eval <= close;
      if (acc_vld) begin
        tot_q <= tot_d; iacc_q <= iacc_d; imiss_q <= imiss_d;
        dacc_q <= dacc_d; dmiss_q <= dmiss_d;
      end
      if (close) begin
        snap_iacc <= iacc_n; snap_imiss <= imiss_n;
        snap_dacc <= dacc_n; snap_dmiss <= dmiss_n;
      end
    end
  end
endmodule

// File: rtl/rp_decide.sv
module rp_decide
  import repart_pkg::*;
#(
  parameter int CNT_W     = 17,
  parameter int PW        = 4,
  parameter int THR_NUM   = 2,
  parameter int THR_DEN   = 100,
  parameter int MIN_IWAYS = 1,
  parameter int MAX_IWAYS = 7
) (
  input  logic [CNT_W-1:0] iacc,
  input  logic [CNT_W-1:0] imiss,
  input  logic [CNT_W-1:0] dacc,
  input  logic [CNT_W-1:0] dmiss,
  input  logic [PW-1:0]    part,
  output step_e            step
);
  localparam int K_MAX  = (THR_NUM > THR_DEN) ? THR_NUM : THR_DEN;
  localparam int PROD_W = 2 * CNT_W + $clog2(K_MAX + 1) + 1;
  localparam logic [PROD_W-1:0] DEN_V = PROD_W'(THR_DEN);
  localparam logic [PROD_W-1:0] NUM_V = PROD_W'(THR_NUM);

  logic [PROD_W-1:0] i_side, d_side, margin;
  logic              both_seen;

  always_comb begin
    i_side    = PROD_W'(imiss) * PROD_W'(dacc) * DEN_V;
    d_side    = PROD_W'(dmiss) * PROD_W'(iacc) * DEN_V;
    margin    = PROD_W'(iacc) * PROD_W'(dacc) * NUM_V;
    both_seen = (iacc != '0) && (dacc != '0);
    step      = STEP_NONE;
    if (both_seen) begin
      if ((i_side > d_side + margin) && (part < PW'(MAX_IWAYS)))
        step = STEP_UP;
      else if ((d_side > i_side + margin) && (part > PW'(MIN_IWAYS)))
        step = STEP_DOWN;
    end
  end
endmodule

// File: rtl/rp_inv_walker.sv
module rp_inv_walker
  import repart_pkg::*;
#(
  parameter int WAYS       = 8,
  parameter int SETS       = 64,
  parameter int INIT_IWAYS = 4,
  parameter int PW         = 4,
  parameter int WW         = 3,
  parameter int SW         = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          eval,
  input  step_e         step,
  output logic [PW-1:0] part,
  output logic          busy,
  output logic [WW-1:0] way,
  output logic [SW-1:0] set_idx
);
  logic [PW-1:0] part_d, tgt_q, tgt_d;
  logic          busy_d, start, last;
  logic [WW-1:0] way_d;
  logic [SW-1:0] set_d;

  always_comb begin
    start  = eval && !busy && (step != STEP_NONE);
    last   = busy && (set_idx == SW'(SETS - 1));
    part_d = part;
    busy_d = busy;
    way_d  = way;
    set_d  = set_idx;
    tgt_d  = tgt_q;
    if (start) begin
      busy_d = 1'b1;
      set_d  = '0;
      if (step == STEP_UP) begin
        way_d = WW'(part);
        tgt_d = part + 1'b1;
      end else begin
        way_d = WW'(part - 1'b1);
        tgt_d = part - 1'b1;
      end
    end else if (last) begin
      busy_d = 1'b0;
      part_d = tgt_q;
    end else if (busy) begin
      set_d = set_idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      part    <= PW'(INIT_IWAYS);
      busy    <= 1'b0;
      way     <= '0;
      set_idx <= '0;
      tgt_q   <= PW'(INIT_IWAYS);
    end else begin
      part    <= part_d;
      busy    <= busy_d;
      way     <= way_d;
      set_idx <= set_d;
      tgt_q   <= tgt_d;
    end
  end
endmodule

// File: rtl/repart_ctrl.sv
module repart_ctrl
  import repart_pkg::*;
#(
  parameter int WAYS       = 8,
  parameter int SETS       = 64,
  parameter int PERIOD     = 100000,
  parameter int THR_NUM    = 2,
  parameter int THR_DEN    = 100,
  parameter int MIN_IWAYS  = 1,
  parameter int MAX_IWAYS  = 7,
  parameter int INIT_IWAYS = 4,
  localparam int PW = $clog2(WAYS + 1),
  localparam int WW = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int SW = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_vld_i,
  input  logic          acc_is_data_i,
  input  logic          acc_miss_i,
  output logic [PW-1:0] part_o,
  output logic          busy_o,
  output logic          inv_vld_o,
  output logic [WW-1:0] inv_way_o,
  output logic [SW-1:0] inv_set_o
);
  localparam int CNT_W = $clog2(PERIOD + 1);

  logic [CNT_W-1:0] s_iacc, s_imiss, s_dacc, s_dmiss;
  logic             eval;
  step_e            step;
  logic             busy;

  rp_epoch_cnt #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .acc_vld(acc_vld_i), .acc_is_data(acc_is_data_i), .acc_miss(acc_miss_i),
    .snap_iacc(s_iacc), .snap_imiss(s_imiss),
    .snap_dacc(s_dacc), .snap_dmiss(s_dmiss),
    .eval(eval)
  );

  rp_decide #(
    .CNT_W(CNT_W), .PW(PW), .THR_NUM(THR_NUM), .THR_DEN(THR_DEN),
    .MIN_IWAYS(MIN_IWAYS), .MAX_IWAYS(MAX_IWAYS)
  ) u_dec (
    .iacc(s_iacc), .imiss(s_imiss), .dacc(s_dacc), .dmiss(s_dmiss),
    .part(part_o), .step(step)
  );

  rp_inv_walker #(
    .WAYS(WAYS), .SETS(SETS), .INIT_IWAYS(INIT_IWAYS),
    .PW(PW), .WW(WW), .SW(SW)
  ) u_walk (
    .clk(clk), .rst_n(rst_n), .eval(eval), .step(step),
    .part(part_o), .busy(busy), .way(inv_way_o), .set_idx(inv_set_o)
  );

  assign busy_o    = busy;
  assign inv_vld_o = busy;
endmodule

// File: rtl/repart_ctrl_chk.sv
module repart_ctrl_chk #(
  parameter int SETS      = 64,
  parameter int MIN_IWAYS = 1,
  parameter int MAX_IWAYS = 7,
  parameter int PW        = 4,
  parameter int WW        = 3,
  parameter int SW        = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic [PW-1:0] part_o,
  input logic          busy_o,
  input logic          inv_vld_o,
  input logic [WW-1:0] inv_way_o,
  input logic [SW-1:0] inv_set_o
);
  assert_walk_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && inv_set_o != SW'(SETS - 1)) |=>
      (busy_o && inv_vld_o && int'(inv_set_o) == int'($past(inv_set_o)) + 1));

  assert_walk_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (inv_set_o == '0));

  assert_walk_way_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (int'(inv_way_o) == int'(part_o) || int'(inv_way_o) + 1 == int'(part_o)));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> $stable(part_o));

  assert_one_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (part_o != $past(part_o)) |->
      ($fell(busy_o) && (int'(part_o) == int'($past(part_o)) + 1 ||
                         int'(part_o) + 1 == int'($past(part_o)))));

  assert_bounds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(part_o) >= MIN_IWAYS && int'(part_o) <= MAX_IWAYS));
endmodule

bind repart_ctrl repart_ctrl_chk #(
  .SETS(SETS), .MIN_IWAYS(MIN_IWAYS), .MAX_IWAYS(MAX_IWAYS),
  .PW(PW), .WW(WW), .SW(SW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .part_o(part_o), .busy_o(busy_o),
  .inv_vld_o(inv_vld_o), .inv_way_o(inv_way_o), .inv_set_o(inv_set_o)
);

// File: tb/tb_repart_ctrl.sv
module tb_repart_ctrl;
  localparam int WAYS = 8, SETS = 4, PERIOD = 100;
  localparam int MINW = 2, MAXW = 6, INITW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_vld = 1'b0, acc_is_data = 1'b0, acc_miss = 1'b0;
  logic [3:0] part_o;
  logic busy_o, inv_vld_o;
  logic [2:0] inv_way_o;
  logic [1:0] inv_set_o;

  int n_tests = 0, n_fail = 0;
  bit cmp_on = 0;

  always #2 clk = ~clk;

  repart_ctrl #(
    .WAYS(WAYS), .SETS(SETS), .PERIOD(PERIOD), .THR_NUM(2), .THR_DEN(100),
    .MIN_IWAYS(MINW), .MAX_IWAYS(MAXW), .INIT_IWAYS(INITW)
  ) dut (
    .clk(clk), .rst_n(rst_n), .acc_vld_i(acc_vld), .acc_is_data_i(acc_is_data),
    .acc_miss_i(acc_miss), .part_o(part_o), .busy_o(busy_o), .inv_vld_o(inv_vld_o),
    .inv_way_o(inv_way_o), .inv_set_o(inv_set_o)
  );

  // behavioural reference
  int m_part, m_busy, m_set, m_way, m_tgt, m_eval;
  int m_tot, m_ia, m_im, m_da, m_dm;
  longint s_ia, s_im, s_da, s_dm;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_part = INITW; m_busy = 0; m_set = 0; m_way = 0; m_tgt = INITW; m_eval = 0;
      m_tot = 0; m_ia = 0; m_im = 0; m_da = 0; m_dm = 0;
      s_ia = 0; s_im = 0; s_da = 0; s_dm = 0;
    end else begin
      if (m_busy != 0) begin
        if (m_set == SETS - 1) begin m_busy = 0; m_part = m_tgt; end
        else m_set++;
      end else if (m_eval != 0 && s_ia != 0 && s_da != 0) begin
        longint il, dl, thr;
        il = s_im * s_da * 100; dl = s_dm * s_ia * 100; thr = 2 * s_ia * s_da;
        if (il > dl + thr && m_part < MAXW) begin
          m_busy = 1; m_set = 0; m_way = m_part; m_tgt = m_part + 1;
        end else if (dl > il + thr && m_part > MINW) begin
          m_busy = 1; m_set = 0; m_way = m_part - 1; m_tgt = m_part - 1;
        end
      end
      m_eval = 0;
      if (acc_vld) begin
        m_tot++;
        if (acc_is_data) begin m_da++; if (acc_miss) m_dm++; end
        else begin m_ia++; if (acc_miss) m_im++; end
        if (m_tot == PERIOD) begin
          s_ia = m_ia; s_im = m_im; s_da = m_da; s_dm = m_dm;
          m_tot = 0; m_ia = 0; m_im = 0; m_da = 0; m_dm = 0; m_eval = 1;
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (cmp_on) begin
      check(int'(part_o) == m_part, "R9 partition vs model", int'(part_o), m_part);
      check(int'(busy_o) == m_busy, "R8 busy vs model", int'(busy_o), m_busy);
      check(int'(inv_vld_o) == m_busy, "R8 inv_vld vs model", int'(inv_vld_o), m_busy);
      if (m_busy != 0) begin
        check(int'(inv_way_o) == m_way, "R8 inv_way vs model", int'(inv_way_o), m_way);
        check(int'(inv_set_o) == m_set, "R8 inv_set vs model", int'(inv_set_o), m_set);
      end
    end
  end

  task automatic access(input bit is_d, input bit miss);
    @(negedge clk);
    acc_vld = 1'b1; acc_is_data = is_d; acc_miss = miss;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      acc_vld = 1'b0; acc_is_data = 1'b0; acc_miss = 1'b0;
    end
  endtask

  // ni instruction accesses (mi misses), then nd data accesses (md misses)
  task automatic burst(input int ni, input int mi, input int nd, input int md);
    for (int k = 0; k < ni; k++) begin
      access(1'b0, k < mi);
      if (k % 7 == 3) idle(1);
    end
    for (int k = 0; k < nd; k++) access(1'b1, k < md);
    idle(1);
  endtask

  task automatic epoch(input int ni, input int mi, input int nd, input int md,
                       input int exp_part, input string tag);
    burst(ni, mi, nd, md);
    idle(SETS + 6);
    check(int'(part_o) == exp_part, tag, int'(part_o), exp_part);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    check(int'(part_o) == INITW, "R1 reset partition", int'(part_o), INITW);
    check(busy_o == 1'b0, "R1 reset busy", int'(busy_o), 0);
    check(inv_vld_o == 1'b0, "R1 reset inv_vld", int'(inv_vld_o), 0);
    cmp_on = 1;

    epoch(50, 10, 50, 1, 5, "R3 instruction worse grows");
    epoch(50, 1, 50, 0, 5, "R5 gap equal to threshold holds");
    epoch(50, 2, 50, 0, 6, "R3 gap above threshold grows");
    epoch(50, 20, 50, 0, 6, "R6 upper limit holds");
    epoch(100, 50, 0, 0, 6, "R7 no data accesses holds");
    epoch(50, 0, 50, 30, 5, "R4 data worse shrinks");
    epoch(50, 0, 50, 30, 4, "R4 data worse shrinks again");
    epoch(50, 3, 50, 3, 4, "R5 equal rates hold");
    epoch(50, 0, 50, 30, 3, "R10 one step per epoch");
    epoch(50, 0, 50, 50, 2, "R4 shrink to lower limit");
    epoch(50, 0, 50, 50, 2, "R6 lower limit holds");
    epoch(0, 0, 100, 40, 2, "R7 no instruction accesses holds");

    // R2: 99 accesses must not evaluate; the 100th must
    burst(50, 25, 49, 0);
    idle(SETS + 6);
    check(busy_o == 1'b0, "R2 no walk before PERIOD", int'(busy_o), 0);
    check(int'(part_o) == 2, "R2 no change before PERIOD", int'(part_o), 2);
    epoch(0, 0, 1, 0, 3, "R2 evaluation on PERIOD-th access");
    epoch(50, 20, 50, 0, 4, "R2 counters restart next epoch");

    cmp_on = 0;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule